// File: doc/BRIEF.md
# Token-Chain Bus Ownership Arbiter

This block decides which of several devices owns a shared bus without any central arbiter. Each device has its own arbitration cell. The cells sit in a chain, and a single-bit token passes from each cell's output to the next cell's input. Three shared lines tie the chain together: the token itself, a busy line that is high while some cell owns the bus, and a request line that tells the current owner that others are waiting.

A cell that wants the bus holds back the token it would pass on, which shuts out every cell further down the chain. A cell can take the bus only when the bus is not busy and its incoming token is high. The head cell always receives a high token, so the position in the chain fixes the priority. A waiting cell loses its chance when a cell nearer the head starts to request before it has won. The winner keeps the bus, and keeps busy high, until its user pulses release.

Each cell is a three-state machine:
- `ST_IDLE`: no request pending, and the token passes through.
- `ST_WAIT`: a request is pending, the token is held back, and the cell has not won yet.
- `ST_OWN`: the cell owns the bus. It drives busy and holds the token back.

The cell moves through these transitions:
- IDLE→OWN when the request is high, the token is in and the bus is free.
- IDLE→WAIT when the request is high but the cell cannot win.
- WAIT→OWN when it wins.
- WAIT→IDLE when the request is withdrawn.
- OWN→IDLE on release.

Top module: `dchain_arbiter`

## Requirements
- R1: After reset `grant_o` is all zero and `busy_o` and `bus_req_o` are low.
- R2: A cell whose request is high while the bus is free and no cell with a lower index requests has its `grant_o` bit high after the next rising clock edge.
- R3: At most one bit of `grant_o` is high in any cycle.
- R4: While a cell owns the bus and does not release it, its grant bit stays high and no other cell is granted, whatever the requests do.
- R5: When the owner's `rel_i` bit is high at a rising edge, its grant bit and `busy_o` are low after that edge. The next winner is granted one edge later.
- R6: Among cells that request in the same cycle while the bus is free, the one with the lowest index (bit 0 is nearest the head) wins.
- R7: A cell that is waiting while the bus is busy is overtaken by a cell with a lower index that starts requesting before the bus is freed.
- R8: `bus_req_o` is high exactly when some cell that does not own the bus has its `req_i` bit high. It follows `req_i` within the same cycle.
- R9: A `rel_i` bit of a cell that does not own the bus has no effect on `grant_o` or `busy_o`.
- R10: A request that is withdrawn before it is granted leaves no grant behind.
- R11: `busy_o` is high exactly when some bit of `grant_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Per-cell bus request, level held until granted |
| rel_i | input | N | Per-cell release pulse from the current owner |
| grant_o | output | N | Per-cell registered ownership flag |
| busy_o | output | 1 | Shared busy line, OR of all owners |
| bus_req_o | output | 1 | Shared request line, OR of pending non-owner requests |

## Verification
The chain is driven with several request patterns:
- A lone requester on a free bus shows the basic grant latency.
- Several simultaneous requesters on a free bus show position priority.
- A late request from a cell nearer the head while a farther cell waits behind a busy bus shows pre-emption, which separates position priority from first-come order.
- A release from a cell that does not own the bus, a request withdrawn while waiting, and an owner that releases while other cells queue cover the ignored-input and hand-over cases.

The shared request line is compared in every cycle against the bench's own model of which non-owners are requesting.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } cell_state_e;

endpackage

// File: rtl/dchain_or_line.sv
module dchain_or_line #(
    parameter int W = 4
) (
    input  logic [W-1:0] drv_i,
    output logic         line_o
);
    // Logical stand-in for an open-collector shared line
    assign line_o = |drv_i;
endmodule

// File: rtl/dchain_cell.sv
module dchain_cell
    import dchain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rel_i,
    input  logic tok_i,
    input  logic bus_busy_i,
    output logic tok_o,
    output logic busy_o,
    output logic pend_o,
    output logic grant_o
);
    cell_state_e state_q, state_d;
    logic        can_win;

    assign can_win = tok_i && !bus_busy_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) state_d = can_win ? ST_OWN : ST_WAIT;
            end
            ST_WAIT: begin
                if (!req_i)       state_d = ST_IDLE;
                else if (can_win) state_d = ST_OWN;
            end
            ST_OWN: begin
                if (rel_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tok_o   = 1'b0;
        busy_o  = 1'b0;
        pend_o  = 1'b0;
        grant_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tok_o  = tok_i && !req_i;
                pend_o = req_i;
            end
            ST_WAIT: begin
                tok_o  = tok_i && !req_i;
                pend_o = req_i;
            end
            ST_OWN: begin
                busy_o  = 1'b1;
                grant_o = 1'b1;
            end
            default: begin
                tok_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dchain_arbiter.sv
module dchain_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] rel_i,
    output logic [N-1:0] grant_o,
    output logic         busy_o,
    output logic         bus_req_o
);
    localparam int TOKW = N + 1;

    logic [TOKW-1:0] tok;
    logic [N-1:0]    busy_drv;
    logic [N-1:0]    pend_drv;
    logic            bus_busy;

    assign tok[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_cell
        dchain_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (req_i[i]),
            .rel_i     (rel_i[i]),
            .tok_i     (tok[i]),
            .bus_busy_i(bus_busy),
            .tok_o     (tok[i+1]),
            .busy_o    (busy_drv[i]),
            .pend_o    (pend_drv[i]),
            .grant_o   (grant_o[i])
        );
    end

    dchain_or_line #(.W(N)) u_busy_line (.drv_i(busy_drv), .line_o(bus_busy));
    dchain_or_line #(.W(N)) u_req_line  (.drv_i(pend_drv), .line_o(bus_req_o));

    assign busy_o = bus_busy;

    logic unused_tail;
    assign unused_tail = tok[N];
endmodule

// File: rtl/dchain_arbiter_chk.sv
module dchain_arbiter_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_i,
    input logic [N-1:0] rel_i,
    input logic [N-1:0] grant_o,
    input logic         busy_o
);
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R3

    AST_BUSY_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (grant_o != '0)); // R11

    AST_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) && ((grant_o & rel_i) == '0) |=> $stable(grant_o)); // R4

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam logic [N-1:0] LOWER = {N{1'b1}} >> (N - i);

        AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            grant_o[i] && rel_i[i] |=> !grant_o[i]); // R5

        AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[i]) |-> $past(req_i[i])); // R2

        AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[i]) |-> (($past(req_i) & LOWER) == '0)); // R6
    end
endmodule

bind dchain_arbiter dchain_arbiter_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .rel_i  (rel_i),
    .grant_o(grant_o),
    .busy_o (busy_o)
);

// File: tb/sim_dchain_arbiter.sv
module sim_dchain_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] rel_i = '0;
    logic [N-1:0] grant_o;
    logic         busy_o;
    logic         bus_req_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [N-1:0] g;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    logic [N-1:0] model_g = '0;

    always #5 clk = ~clk;

    dchain_arbiter #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rel_i(rel_i),
        .grant_o(grant_o), .busy_o(busy_o), .bus_req_o(bus_req_o)
    );

    // Monitor: compare results of the previous edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (grant_o !== e.g) begin
                n_bad++;
                $display("FAIL %s grant act=%b exp=%b", e.tag, grant_o, e.g);
            end
            n_cmp++;
            if (busy_o !== (e.g != '0)) begin
                n_bad++;
                $display("FAIL R11 (%s) busy act=%b exp=%b", e.tag, busy_o, (e.g != '0));
            end
        end
    end

    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] rl,
                        input logic [N-1:0] eg, input string tag);
        logic eb;
        @(negedge clk);
        #1;
        req_i = rq;
        rel_i = rl;
        #1;
        eb = |(rq & ~model_g);
        n_cmp++;
        if (bus_req_o !== eb) begin
            n_bad++;
            $display("FAIL R8 (%s) bus_req act=%b exp=%b", tag, bus_req_o, eb);
        end
        sb.push_back('{g: eg, tag: tag});
        model_g = eg;
    endtask

    initial begin : wdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if (grant_o !== '0 || busy_o !== 1'b0 || bus_req_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset act=%b/%b/%b exp=0000/0/0", grant_o, busy_o, bus_req_o);
        end
        rst_n = 1'b1;

        step(4'b0001, 4'b0000, 4'b0001, "R2 lone request");
        step(4'b0001, 4'b0000, 4'b0001, "R4 hold");
        step(4'b0100, 4'b0000, 4'b0001, "R4 owner keeps while cell2 waits");
        step(4'b0100, 4'b1000, 4'b0001, "R9 foreign release ignored");
        step(4'b0110, 4'b0001, 4'b0000, "R5 release");
        step(4'b0110, 4'b0000, 4'b0010, "R7 upstream overtakes waiter");
        step(4'b0100, 4'b0010, 4'b0000, "R5 release 2");
        step(4'b0100, 4'b0000, 4'b0100, "R2 waiter finally wins");
        step(4'b0000, 4'b0100, 4'b0000, "R5 release 3");
        step(4'b1110, 4'b0000, 4'b0010, "R6 simultaneous");
        step(4'b1100, 4'b0010, 4'b0000, "R5 release 4");
        step(4'b1100, 4'b0000, 4'b0100, "R6 next in line");
        step(4'b1000, 4'b0100, 4'b0000, "R5 release 5");
        step(4'b1000, 4'b0000, 4'b1000, "R2 tail cell");
        step(4'b0001, 4'b0000, 4'b1000, "R4 head waits behind busy");
        step(4'b0000, 4'b0000, 4'b1000, "R10 withdraw");
        step(4'b0000, 4'b1000, 4'b0000, "R5 release 6");
        step(4'b0000, 4'b0000, 4'b0000, "R10 no stale grant");
        step(4'b1001, 4'b0000, 4'b0001, "R6 head beats tail");
        step(4'b0000, 4'b0001, 4'b0000, "R5 release 7");
        step(4'b0100, 4'b0000, 4'b0100, "R2 mid cell");
        step(4'b0110, 4'b0100, 4'b0000, "R5 release with queue");
        step(4'b0110, 4'b0000, 4'b0010, "R7 hand-over by position");
        step(4'b0000, 4'b0010, 4'b0000, "R5 release 8");
        step(4'b0000, 4'b0000, 4'b0000, "R3 idle");

        @(negedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule